// File: doc/BRIEF.md
# Asynchronous Static RAM Byte Access Controller

This block lets a clocked on-chip requester read and write single bytes in an external asynchronous static RAM of 1M x 8. The requester offers an address, a direction flag and, for writes, a byte on a valid/ready port. The controller then plays out the access on the RAM pins: a 20-bit address, a select pair of opposite polarity (`mem_ce1_n` low-active, `mem_ce2` high-active), a low-active write strobe, a low-active output enable, and an 8-bit data bus. The bus is split into an output byte, an input byte and a driver enable, so that a pad ring can build the three-state pin.

The RAM has no clock, so its nanosecond limits are turned into whole clock counts when the design is built. The counts come from the clock period and from the read cycle time, the output-enable access time, the bus release time and the write pulse width, each rounded up. A read holds address, select and output enable steady for the counted number of cycles. It samples the bus once, on the last edge of that window, and returns the byte with a one-cycle `rd_valid` pulse. A read is followed by a counted float gap before anything else can start. A write has three phases: a setup cycle, a counted strobe pulse and a hold cycle. The data drivers are on for the whole write. Between accesses the RAM is left deselected, in its low-power standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the pins sit in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access has fully finished. That is RD_CYC+HZ_CYC cycles for a read and WP_CYC+2 cycles for a write.
- R3: During a read, the chip is selected (`mem_ce1_n`=0, `mem_ce2`=1) with `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD_CYC cycles. During that time `mem_addr` equals the requested address. RD_CYC = ceil(max(T_RC_NS, T_OE_NS) / CLK_PERIOD_NS).
- R4: Each read gives exactly one `rd_valid` pulse, one cycle long. `rd_data` carries the byte on the bus at the last edge of the read window. That byte equals the value most recently written to that address.
- R5: After a read the chip stays deselected, and `req_ready` stays low, for HZ_CYC = ceil(T_HZ_NS / CLK_PERIOD_NS) cycles. The data drivers are never enabled sooner than HZ_CYC cycles after the RAM's outputs were last enabled.
- R6: A write selects the chip with `mem_oe_n`=1 throughout. It starts with one cycle of `mem_we_n`=1, then holds `mem_we_n`=0 for WP_CYC cycles, then gives one more cycle of `mem_we_n`=1. The address stays constant while the chip is selected. WP_CYC = max(ceil(T_WP_NS / CLK_PERIOD_NS), RD_CYC-2, 1).
- R7: `mem_dq_oe` is high only during the WP_CYC+2 selected cycles of a write. It is never high while `mem_oe_n` is low, so the controller and the RAM never drive the bus together.
- R8: A write produces no `rd_valid` pulse.
- R9: A low `rst_n`, sampled on a clock edge, abandons any access in flight and puts the pins in standby. After `rst_n` returns high, `req_ready` stays low for HZ_CYC cycles before requests are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Requester offers an access |
| req_ready | output | 1 | Controller can take an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Byte to store on a write |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the read byte |
| rd_data | output | DATA_W | Byte returned by the last read |
| mem_addr | output | ADDR_W | Address pins of the RAM |
| mem_ce1_n | output | 1 | Low-active chip select |
| mem_ce2 | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_dq_o | output | DATA_W | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_i | input | DATA_W | Byte received from the data bus |

## Verification
The assertions assume two things about the inputs. First, the requester only changes its request fields in cycles where no request is being taken. Second, `rst_n` is a clean synchronous level. The RAM model behind the pins is assumed to honour the select truth table and its 55/30/25 ns limits, driving a wrong byte until data is valid and holding the bus for the full release time. The stimulus keeps within these assumptions: it sets requests on falling clock edges and drops `req_valid` right after acceptance. It picks addresses from a small random pool plus the two end addresses, so that reads hit written data. It orders accesses so that read-to-write turnarounds occur often and are checked for bus overlap.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and compile-time arithmetic for the static RAM
// access controller. Assumes all timing values are positive nanosecond counts.
package sram_ctrl_pkg;

    // Access sequencer states; the pin levels are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD       = 3'd1,
        ST_RD_FLOAT = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } seq_state_t;

    // Pin levels for one cycle, grouped so they are registered together.
    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    // Standby pin levels: deselected, strobes high, drivers off.
    localparam pin_ctl_t PINS_STANDBY = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    // Larger of two unsigned counts.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
// Module: down-counting wait-state timer.
// Loaded with (cycles - 1) as the sequencer enters a counted state, so the
// state lasts (load value + 1) cycles. Reports expiry while the count is zero.
// Assumes load requests come only from the sequencer on state entry.
module sram_wait_timer #(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag seen by the sequencer.
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/sram_access_seq.sv
`timescale 1ns/1ps
// Module: access sequencer.
// Walks one read (window, float gap) or one write (setup, strobe, hold) per
// accepted request and tells the timer how long each counted state lasts.
// Reset lands in the float state so a bus left driven by an abandoned read has
// time to release. Assumes the timer is loaded in the same cycle a state is entered.
module sram_access_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned RD_CYC = 6,
    parameter int unsigned HZ_CYC = 3,
    parameter int unsigned WP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             req_ready,
    output logic             accept,
    output logic             sample,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_t       state_d
);

    seq_state_t state_q;

    // State register; reset enters the float gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RD_FLOAT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, timer loads and strobes for the current cycle.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        sample   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD: begin
                if (tmr_expired) begin
                    sample   = 1'b1;
                    state_d  = ST_RD_FLOAT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HZ_CYC - 1);
                end
            end
            ST_RD_FLOAT: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Requests are taken only when nothing is in flight.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
// Module: pin register stage.
// Registers every RAM pin from the sequencer's next state, so the pins change
// only on clock edges and without decode glitches. Latches the request address
// and write byte on acceptance, and captures the read byte on the sample strobe.
// Assumes accept and sample are single-cycle strobes from the sequencer.
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_d,
    input  logic              accept,
    input  logic              sample,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    pin_ctl_t          pins_d;
    pin_ctl_t          pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Pin levels wanted for the state being entered.
    always_comb begin
        pins_d = PINS_STANDBY;
        unique case (state_d)
            ST_RD: begin
                pins_d = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                pins_d = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            end
            ST_WR_PULSE: begin
                pins_d = '{ce1_n: 1'b0, ce2: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            end
            default: begin
                pins_d = PINS_STANDBY;
            end
        endcase
    end

    // Control pin register; reset forces standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= PINS_STANDBY;
        end else begin
            pins_q <= pins_d;
        end
    end

    // Address and write byte are held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read byte capture and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= sample;
            if (sample) begin
                rdata_q <= mem_dq_i;
            end
        end
    end

    // Outputs straight from registers.
    always_comb begin
        mem_addr  = addr_q;
        mem_ce1_n = pins_q.ce1_n;
        mem_ce2   = pins_q.ce2;
        mem_we_n  = pins_q.we_n;
        mem_oe_n  = pins_q.oe_n;
        mem_dq_oe = pins_q.dq_oe;
        mem_dq_o  = wdata_q;
        rd_valid  = rvalid_q;
        rd_data   = rdata_q;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Module: top of the asynchronous static RAM byte access controller.
// Turns RAM nanosecond limits into wait-state counts at build time and joins
// the sequencer, its timer and the pin register stage. Assumes a single
// requester that holds its request fields steady while req_valid is high.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned T_OE_NS       = 30,
    parameter int unsigned T_HZ_NS       = 25,
    parameter int unsigned T_WP_NS       = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned RD_CYC = umax(1, umax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                                  ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
    localparam int unsigned HZ_CYC = umax(1, ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));
    localparam int unsigned WP_MIN = (RD_CYC > 2) ? RD_CYC - 2 : 1;
    localparam int unsigned WP_CYC = umax(WP_MIN, umax(1, ns_to_cyc(T_WP_NS, CLK_PERIOD_NS)));
    localparam int unsigned MAX_CYC = umax(RD_CYC, umax(HZ_CYC, WP_CYC));
    localparam int unsigned CNT_W  = $clog2(MAX_CYC) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             sample;
    seq_state_t       state_d;

    sram_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (HZ_CYC - 1)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_access_seq #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .HZ_CYC (HZ_CYC),
        .WP_CYC (WP_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .req_ready   (req_ready),
        .accept      (accept),
        .sample      (sample),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .state_d     (state_d)
    );

    sram_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) pins_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .accept    (accept),
        .sample    (sample),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_ce1_n (mem_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
// Module: protocol checker bound to the controller top.
// Watches only ports. Keeps a saturating count of cycles since the RAM's
// outputs were last enabled, to check the bus release gap. Assumes a
// synchronous active-low reset.
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned HZ_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    localparam int unsigned GAP_W = $clog2(HZ_CYC + 2) + 1;

    logic             sel;
    logic [GAP_W-1:0] gap_q;

    // Chip is selected only with both enables active.
    always_comb begin
        sel = !mem_ce1_n && mem_ce2;
    end

    // Cycles since the RAM last had its outputs enabled, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (sel && !mem_oe_n) begin
            gap_q <= '0;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_standby_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r4_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && $past(sel)));

    a_r5_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (gap_q >= GAP_W'(HZ_CYC)));

    a_r6_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (sel && mem_oe_n && mem_dq_oe));

    a_r6_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(sel));

    a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> sel);

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

    a_r7_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .HZ_CYC (HZ_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: drives the controller against a timed model of the RAM, which
// follows the select truth table and returns a wrong byte until data is valid.
// Scores every access against expected values computed here.
module sram_async_ctrl_tb_top;

    localparam int CLK_NS = 10;
    localparam int RD_CYC = (55 + CLK_NS - 1) / CLK_NS;
    localparam int HZ_CYC = (25 + CLK_NS - 1) / CLK_NS;
    localparam int WP_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [19:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i;

    int n_checks = 0;
    int n_fails  = 0;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // Contents of a location nobody has written yet.
    function automatic logic [7:0] init_byte(input logic [19:0] a);
        return a[7:0] ^ a[19:12] ^ 8'h5C;
    endfunction

    // ---------------- RAM model (1 ns ticks, offset half a ns from edges)
    logic [7:0] ram [int];
    logic [7:0] ram_dq = '0;
    bit         ram_drive = 0;
    realtime    t_addr = -1000.0, t_sel = -1000.0, t_oe = -1000.0, t_off = -1000.0;
    logic [19:0] prev_addr = '0, we_addr = '0;
    bit         prev_sel = 0, prev_rd = 0, prev_oe_n = 1, prev_we_n = 1;
    int         contention = 0;
    int         we_addr_moves = 0;

    assign mem_dq_i = ram_dq;

    function automatic logic [7:0] ram_read(input logic [19:0] a);
        return ram.exists(int'(a)) ? ram[int'(a)] : init_byte(a);
    endfunction

    task automatic ram_tick();
        realtime now;
        bit sel, rd;
        logic [7:0] d;
        now = $realtime;
        sel = !mem_ce1_n && mem_ce2;
        rd  = sel && mem_we_n && !mem_oe_n;
        if (mem_addr != prev_addr) t_addr = now;
        if (sel && !prev_sel) t_sel = now;
        if (!mem_oe_n && prev_oe_n) t_oe = now;
        if (rd) begin
            d = ram_read(mem_addr);
            ram_drive = 1;
            if (now >= t_addr + 55.0 && now >= t_sel + 55.0 && now >= t_oe + 30.0) ram_dq = d;
            else ram_dq = ~d;
        end else begin
            if (prev_rd) t_off = now;
            if (ram_drive && now >= t_off + 25.0) ram_drive = 0;
        end
        if (sel && !mem_we_n && prev_we_n) we_addr = mem_addr;
        if (sel && mem_we_n && !prev_we_n) begin
            if (mem_addr != we_addr) we_addr_moves++;
            if (mem_dq_oe) ram[int'(mem_addr)] = mem_dq_o;
        end
        if (ram_drive && mem_dq_oe) contention++;
        prev_addr = mem_addr; prev_sel = sel; prev_rd = rd;
        prev_oe_n = mem_oe_n; prev_we_n = mem_we_n;
    endtask

    initial begin
        #0.5;
        forever begin
            ram_tick();
            #1;
        end
    end

    // ---------------- scoreboard
    logic [7:0] exp_mem [int];

    function automatic logic [7:0] exp_byte(input logic [19:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_byte(a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    function automatic bit pins_standby();
        return mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe;
    endfunction

    // Called at a negedge; returns at the negedge where ready is high.
    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_read(input logic [19:0] a);
        int act = 0, vcnt = 0, busy = 0, bad_addr = 0;
        logic [7:0] got = '0;
        logic [7:0] expv;
        expv = exp_byte(a);
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 8'($urandom);
        @(negedge clk);
        req_valid = 0;
        while (!req_ready) begin
            busy++;
            if (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n) begin
                act++;
                if (mem_addr != a) bad_addr++;
            end
            if (rd_valid) begin vcnt++; got = rd_data; end
            @(negedge clk);
            if (busy > 100) break;
        end
        check(act == RD_CYC, "R3 read window cycles", act, RD_CYC);
        check(bad_addr == 0, "R3 read address", bad_addr, 0);
        check(vcnt == 1, "R4 rd_valid pulses", vcnt, 1);
        check(got == expv, "R4 read data", got, expv);
        check(busy == RD_CYC + HZ_CYC, "R2 R5 read busy cycles", busy, RD_CYC + HZ_CYC);
        check(pins_standby(), "R1 standby after read", 0, 1);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [7:0] d);
        int sel_c = 0, we_c = 0, oe_c = 0, rdv = 0, oel = 0, busy = 0;
        bit first_ok = 0, last_we_n = 0, seen = 0;
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_wdata = 8'($urandom);
        while (!req_ready) begin
            busy++;
            if (!mem_ce1_n && mem_ce2) begin
                if (!seen) first_ok = mem_we_n;
                seen = 1;
                sel_c++;
                last_we_n = mem_we_n;
            end
            if (!mem_we_n) we_c++;
            if (mem_dq_oe) oe_c++;
            if (!mem_oe_n) oel++;
            if (rd_valid) rdv++;
            @(negedge clk);
            if (busy > 100) break;
        end
        exp_mem[int'(a)] = d;
        check(we_c == WP_CYC, "R6 strobe cycles", we_c, WP_CYC);
        check(sel_c == WP_CYC + 2 && first_ok && last_we_n, "R6 setup/hold framing", sel_c, WP_CYC + 2);
        check(oel == 0, "R6 oe high in write", oel, 0);
        check(oe_c == WP_CYC + 2, "R7 driver cycles", oe_c, WP_CYC + 2);
        check(rdv == 0, "R8 no rd_valid on write", rdv, 0);
        check(busy == WP_CYC + 2, "R2 write busy cycles", busy, WP_CYC + 2);
    endtask

    // Counts ready-low negedges right after reset release.
    task automatic release_and_count(input string req);
        int low = 0;
        @(negedge clk);
        rst_n = 1;
        while (!req_ready && low < 50) begin low++; @(negedge clk); end
        check(low == HZ_CYC, req, low, HZ_CYC);
        check(pins_standby(), "R1 standby with ready", 0, 1);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary_and_end();
    end

    initial begin
        logic [19:0] pool [10];
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);
        pool[8] = 20'h00000;
        pool[9] = 20'hFFFFF;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pins_standby(), "R1 standby in reset", 0, 1);
        check(!req_ready, "R1 ready low in reset", req_ready, 0);
        check(!rd_valid, "R1 rd_valid low in reset", rd_valid, 0);
        release_and_count("R9 ready hold-off after reset");

        // Directed corners: end addresses, unwritten read, read-to-write turnaround
        do_read(20'h12345);
        do_write(20'h00000, 8'hA5);
        do_write(20'hFFFFF, 8'h3C);
        do_read(20'hFFFFF);
        do_write(20'h00001, 8'hFF);
        do_read(20'h00000);
        do_read(20'h00001);
        do_write(20'h00001, 8'h00);
        do_read(20'h00001);

        // R9: reset in the middle of a read
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = pool[0];
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(pins_standby(), "R9 standby after mid-access reset", 0, 1);
        check(!req_ready, "R9 ready low during reset", req_ready, 0);
        release_and_count("R9 ready hold-off after mid-access reset");

        // Random mix over the address pool
        for (int k = 0; k < 80; k++) begin
            logic [19:0] a;
            a = pool[$urandom_range(0, 9)];
            if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
            else do_read(a);
        end

        repeat (5) @(negedge clk);
        check(contention == 0, "R7 bus contention ticks", contention, 0);
        check(we_addr_moves == 0, "R6 address moved during strobe", we_addr_moves, 0);
        summary_and_end();
    end

endmodule